// File: doc/BRIEF.md
# Rewindable FIFO with Half-Level Flag

This block is a first-in first-out buffer for 9-bit words. Its depth is a power of two, set by a parameter between 256 and 4096. It runs in one clock domain. The write strobe and the read strobe are active low and are sampled on each rising clock edge as enables. The block drives three active-low status flags: empty, over-half and full. An active-low synchronous master reset clears the buffer.

A rewind input moves the read side back to physical address zero without touching the stored words, so a receiver can replay a packet it has not acknowledged. The flags are then worked out again from the new distance between the two pointers. Read data comes out one cycle after an accepted read, together with an enable that stands in for a tri-state output: while the enable is low the data bus reads zero.

Rewind gives a correct replay only while the total number of words written since the last reset is no more than the depth. Behaviour after the write pointer has wrapped is not defined.

Top module: `fifo_rt`

## Requirements
- R1: In the cycle after a clock edge that samples `mrst_n` low, `empty_n` is 0, `half_n` is 1, `full_n` is 1 and `dout_en` is 0.
- R2: A write strobe (`wr_n` = 0) while the buffer holds DEPTH words stores nothing. The word count stays the same, and the oldest word is still the next word read.
- R3: A read strobe (`rd_n` = 0) while the buffer is empty does not advance the read side. In the next cycle `dout_en` stays 0.
- R4: `half_n` is 0 exactly when the word count is at least DEPTH/2+1. It goes back to 1 as soon as a read brings the count down to DEPTH/2.
- R5: `full_n` is 0 exactly when the count equals DEPTH. `empty_n` is 0 exactly when the count is 0. The count never goes above DEPTH.
- R6: A rewind cycle is a cycle with `rt_n` = 0 and both `wr_n` and `rd_n` = 1. It sets the read address to 0, and the following reads return the words again from the first one written since reset.
- R7: A cycle with `rt_n` = 0 while either strobe is 0 is not a rewind. Any read or write in that cycle is carried out as usual.
- R8: After a rewind, all three flags follow the new count, which equals the number of words written since reset.
- R9: Words written after a rewind are returned by later reads, after the replayed words.
- R10: Reads return words in the order they were written. The word appears on `dout` in the cycle after the accepted read edge.
- R11: `dout_en` is 1 only in the cycle after an accepted read. While `dout_en` is 0, `dout` reads all zeros.
- R12: A cycle with both strobes active on a buffer that is neither empty nor full performs both the read and the write and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | WIDTH | Write data |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind request, active low |
| dout | output | WIDTH | Read data, zero while not enabled |
| dout_en | output | 1 | High in the cycle after an accepted read |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half flag, active low |
| full_n | output | 1 | Full flag, active low |

## Verification
The bench first writes into an empty buffer across the half-depth boundary and on up to full. It then strobes writes against a full buffer and reads against an empty one, which separates the overrun and underrun guards from the plain counting. Rewind runs are used in three ways: after a partial drain, after a complete drain, and with a strobe held during the request. These show whether the pointer returns to zero, whether the flags are worked out again, and whether a request that should be ignored leaks through. A long run of random mixed reads and writes then exercises simultaneous operations and pointer wrap-around against the ordered contents of a queue model.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic rewind;
  } fifo_op_t;
endpackage

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo_rt_ptrs.sv
module fifo_rt_ptrs
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rt_n,
  output fifo_op_t      op,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   cnt_next
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW:0] wptr, rptr, cnt;
  logic [AW:0] wptr_next, rptr_next;

  always_comb begin
    op.rewind = !rt_n && wr_n && rd_n;
    op.rd     = !rd_n && (cnt != '0);
    op.wr     = !wr_n && (cnt != FULL_CNT);
    wptr_next = op.wr ? wptr + 1'b1 : wptr;
    if (op.rewind)  rptr_next = '0;
    else if (op.rd) rptr_next = rptr + 1'b1;
    else            rptr_next = rptr;
    if (op.rewind) cnt_next = wptr;
    else begin
      case ({op.wr, op.rd})
        2'b10:   cnt_next = cnt + 1'b1;
        2'b01:   cnt_next = cnt - 1'b1;
        default: cnt_next = cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr_next;
      rptr <= rptr_next;
      cnt  <= cnt_next;
    end
  end

  assign waddr = wptr[AW-1:0];
  assign raddr = rptr[AW-1:0];

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (cnt == FULL_CNT && !wr_n && rd_n) |=> (wptr == $past(wptr)));
  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (cnt == '0 && !rd_n && rt_n) |=> (rptr == $past(rptr)));
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    cnt <= FULL_CNT);
  // R6
  rewind_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!rt_n && rd_n && wr_n) |=> (rptr == '0 && cnt == $past(wptr)));
  // R7
  rewind_gate_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!rt_n && !rd_n && cnt != '0) |=> (rptr == $past(rptr) + 1'b1));
  // R12
  both_ops_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!rd_n && !wr_n && cnt != '0 && cnt != FULL_CNT) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        mrst_n,
  input  logic [AW:0] cnt_next,
  output logic        empty_n,
  output logic        half_n,
  output logic        full_n
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      empty_n <= 1'b0;
      half_n  <= 1'b1;
      full_n  <= 1'b1;
    end else begin
      empty_n <= (cnt_next != '0);
      half_n  <= !(cnt_next > HALF_CNT);
      full_n  <= (cnt_next != FULL_CNT);
    end
  end

  // R5
  empty_excl_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !empty_n |-> (half_n && full_n));
  // R4
  full_implies_half_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !full_n |-> !half_n);
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_n,
  input  logic             rt_n,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en,
  output logic             empty_n,
  output logic             half_n,
  output logic             full_n
);
  localparam int AW = $clog2(DEPTH);

  fifo_op_t         op;
  logic [AW-1:0]    waddr, raddr;
  logic [AW:0]      cnt_next;
  logic [WIDTH-1:0] rdata;

  fifo_rt_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .mrst_n(mrst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .op(op), .waddr(waddr), .raddr(raddr), .cnt_next(cnt_next)
  );

  fifo_rt_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(op.wr), .waddr(waddr), .wdata(din),
    .re(op.rd), .raddr(raddr), .rdata(rdata)
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .mrst_n(mrst_n), .cnt_next(cnt_next),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  always_ff @(posedge clk) begin
    if (!mrst_n) dout_en <= 1'b0;
    else         dout_en <= op.rd;
  end

  assign dout = dout_en ? rdata : '0;

  // R11
  dout_en_src_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    dout_en |-> $past(!rd_n));
  // R3
  empty_no_data_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!empty_n && !rd_n) |=> !dout_en);
  // R11
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !dout_en |-> (dout == '0));
endmodule

// File: tb/tb_fifo_rt.sv
`timescale 1ns/1ps
module tb_fifo_rt;
  localparam int WIDTH = 9;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic mrst_n, wr_n, rd_n, rt_n;
  logic [WIDTH-1:0] din;
  logic [WIDTH-1:0] dout;
  logic dout_en, empty_n, half_n, full_n;

  always #5 clk = ~clk;

  fifo_rt #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
    .clk(clk), .mrst_n(mrst_n), .wr_n(wr_n), .din(din), .rd_n(rd_n),
    .rt_n(rt_n), .dout(dout), .dout_en(dout_en), .empty_n(empty_n),
    .half_n(half_n), .full_n(full_n)
  );

  // behavioural model: every word ever written since reset, plus two indices
  logic [WIDTH-1:0] hist [$];
  int mw, mr;
  logic [WIDTH-1:0] exp_dout;
  logic exp_en;
  int vectors = 0, errors = 0;
  bit done = 0;

  task automatic step(input logic rst_l, input logic w_l, input logic r_l,
                      input logic t_l, input logic [WIDTH-1:0] d, input string tag);
    int c;
    logic [WIDTH-1:0] ed;
    mrst_n = rst_l; wr_n = w_l; rd_n = r_l; rt_n = t_l; din = d;
    @(posedge clk);
    if (!rst_l) begin
      hist.delete(); mw = 0; mr = 0; exp_en = 0;
    end else if (!t_l && w_l && r_l) begin
      mr = 0; exp_en = 0;
    end else begin
      c = mw - mr;
      exp_en = !r_l && (c != 0);
      if (exp_en) begin exp_dout = hist[mr]; mr++; end
      if (!w_l && c != DEPTH) begin hist.push_back(d); mw++; end
    end
    @(negedge clk);
    c = mw - mr;
    ed = exp_en ? exp_dout : '0;
    vectors++;
    if (empty_n !== (c != 0) || half_n !== !(c > DEPTH/2) ||
        full_n !== (c != DEPTH) || dout_en !== exp_en || dout !== ed) begin
      errors++;
      $display("FAIL %s: got e=%b h=%b f=%b en=%b d=%h, expected e=%b h=%b f=%b en=%b d=%h",
               tag, empty_n, half_n, full_n, dout_en, dout,
               c != 0, !(c > DEPTH/2), c != DEPTH, exp_en, ed);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    mrst_n = 0; wr_n = 1; rd_n = 1; rt_n = 1; din = '0;
    @(negedge clk);
    // R1 reset state
    step(0, 1, 1, 1, 0, "R1");
    step(0, 0, 0, 0, 9'h1AA, "R1");
    // R3 read on empty buffer
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, "R3");
    // R4 fill across half boundary
    for (int i = 0; i < DEPTH/2 + 1; i++) step(1, 0, 1, 1, 9'(i * 7 + 3), "R4");
    step(1, 1, 0, 1, 0, "R4");
    step(1, 0, 1, 1, 9'h055, "R4");
    // R5 fill to full
    while (mw - mr < DEPTH) step(1, 0, 1, 1, 9'(mw * 13), "R5");
    // R2 writes to full are dropped, read+write on full only reads
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 9'h1FF, "R2");
    step(1, 0, 0, 1, 9'h100, "R2");
    step(1, 1, 0, 1, 0, "R2");
    // R12 both strobes mid-level
    for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 9'(i + 200), "R12");
    // R10 drain in order, then extra reads on empty
    while (mw != mr) step(1, 1, 0, 1, 0, "R10");
    step(1, 1, 0, 1, 0, "R3");

    // rewind scenarios
    step(0, 1, 1, 1, 0, "R1");
    for (int i = 0; i < 10; i++) step(1, 0, 1, 1, 9'(i + 16), "R6");
    for (int i = 0; i < 6; i++)  step(1, 1, 0, 1, 0, "R6");
    step(1, 1, 1, 0, 0, "R6");
    // R7 rewind request with read active reads normally
    step(1, 1, 0, 0, 0, "R7");
    step(1, 0, 1, 0, 9'h0C3, "R7");
    step(1, 1, 1, 0, 0, "R6");
    // R9 writes after rewind also delivered
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 9'(i + 300), "R9");
    while (mw != mr) step(1, 1, 0, 1, 0, "R9");
    // R8 rewind after full drain re-raises flags
    step(1, 1, 1, 0, 0, "R8");
    step(1, 1, 1, 1, 0, "R8");
    step(0, 1, 1, 1, 0, "R1");
    for (int i = 0; i < 200; i++) step(1, 0, 1, 1, 9'(i ^ 9'h0A5), "R8");
    while (mw != mr) step(1, 1, 0, 1, 0, "R8");
    step(1, 1, 1, 0, 0, "R8");
    step(1, 1, 1, 1, 0, "R8");
    for (int i = 0; i < 80; i++) step(1, 1, 0, 1, 0, "R8");
    step(1, 0, 1, 1, 9'h011, "R8");
    step(1, 1, 1, 0, 0, "R8");
    // R10/R12 random mixed traffic, no rewind
    step(0, 1, 1, 1, 0, "R1");
    for (int i = 0; i < 6000; i++)
      step(1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0 ? 1 : 0), 1,
           9'($urandom_range(0, 511)), "R10");
    for (int i = 0; i < 3000; i++)
      step(1, 1'($urandom_range(0, 2) == 0 ? 1 : 0), 1'($urandom_range(0, 1)), 1,
           9'($urandom_range(0, 511)), "R12");
    finish_run();
  end
endmodule